// File: doc/BRIEF.md
# Serial Character Receiver with Mute and Match

This block receives asynchronous serial characters on a single line. The line is sampled 16 times per bit. Each character carries eight data bits, least significant bit first, between one low start bit and one high stop bit. Each accepted character appears on `rx_data_o` together with a one-cycle `rx_valid_o` strobe. A small register port holds the configuration and a status byte. The port writes control, compare and node-address values, and it issues command strobes for a mute request and for clearing flags.

The receiver can be muted so that it drops traffic meant for other nodes. In address mode (control bit 1 = 1), a character whose top bit is set is an address. An address equal to the node address wakes the receiver. Any other address mutes it. In idle mode (control bit 1 = 0), only the command strobe mutes the receiver. A silent line lasting a full character time wakes it again.

A sticky compare flag catches one programmable byte and can raise an interrupt. A busy flag covers each reception attempt from the confirmed start bit until the stop-bit sample. A framing-error flag is set when the stop bit is sampled low.

Frame engine states (enum in the package), each with its transitions:

- FR_HUNT: on a low sample, goes to FR_START_CHK.
- FR_START_CHK: a high sample at start samples 7, 8 or 9 returns to FR_HUNT. A low sample at 9 goes to FR_START_TAIL.
- FR_START_TAIL: at sample 15, goes to FR_DATA.
- FR_DATA: after the eighth bit, goes to FR_STOP.
- FR_STOP: at sample 8 of the stop bit, returns to FR_HUNT.

Mute states, each with its transitions:

- MT_ACTIVE goes to MT_MUTED on the command strobe, or on a mismatching address in address mode.
- MT_MUTED goes to MT_ACTIVE on a matching address in address mode, or on an idle event in idle mode.

Top module: `uart_mute_rx`

## Requirements
- R1: A frame of low start bit, eight data bits (LSB first) and a high stop bit produces exactly one `rx_valid_o` pulse, with `rx_data_o` equal to the byte, while the receiver is active.
- R2: A low pulse on the line that is high again by start sample 7 is dropped. Busy stays 0 and no character is produced.
- R3: Status bit 0 (busy) is 1 from the confirmed start bit through the data bits. It returns to 0 at the stop-bit sample, whether the frame is good or bad.
- R4: A stop bit sampled low sets status bit 3 (framing error) and produces no `rx_valid_o`. Writing 1 to command bit 2 (register 3) clears the flag.
- R5: A delivered character equal to the compare register (register 1) sets status bit 1. The flag stays set through later characters until 1 is written to command bit 1.
- R6: `irq_o` is 1 exactly while status bit 1 is set and control bit 2 (register 0) is 1.
- R7: While muted, characters produce no `rx_valid_o` and do not set the compare flag.
- R8: In address mode, a character with bit 7 set is an address. If its low 7 bits equal register 2, the receiver goes to MT_ACTIVE and that character is delivered. Otherwise the receiver goes to MT_MUTED and the character is dropped. An idle line does not wake the receiver in this mode.
- R9: Status bit 2 reports MT_MUTED. Writing 1 to command bit 0 mutes the receiver. In idle mode the hardware never mutes by itself, and 160 consecutive high samples seen while muted wake the receiver.
- R10: Status bit 4 (enable acknowledge) takes the value of control bit 0 only while the frame engine is in FR_HUNT. Clearing the enable mid-frame lets the current character complete. While the acknowledge is 0, no character is received.
- R11: After reset, status reads 0x00 and `rx_valid_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line, idle high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 control, 1 compare, 2 node, 3 command |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address: 0 control, 1 compare, 2 node, 3 status |
| rd_data_o | output | 8 | Read data (combinational) |
| rx_valid_o | output | 1 | One-cycle strobe for a delivered character |
| rx_data_o | output | 8 | Last delivered character |
| irq_o | output | 1 | Compare interrupt |

## Verification
Most internal faults show up within one character time. A frame engine stuck in the wrong state shows as busy that never drops or never rises, or as a missing or shifted byte on `rx_data_o`. All of these are visible at the stop-bit sample of that same frame. A wrong mute state shows on the next character: a strobe is present where it should be missing, or the reverse. A bad idle counter only shows once the 160-sample window ends, about ten bit times after the last frame. A lost enable acknowledge shows in the status byte within a cycle once the engine is back in FR_HUNT.

// File: rtl/uart_mute_pkg.sv
package uart_mute_pkg;

    typedef enum logic [2:0] {
        FR_HUNT,
        FR_START_CHK,
        FR_START_TAIL,
        FR_DATA,
        FR_STOP
    } frame_state_t;

    typedef enum logic {
        MT_ACTIVE,
        MT_MUTED
    } mute_state_t;

    localparam logic [1:0] RA_CTRL   = 2'd0;
    localparam logic [1:0] RA_MATCH  = 2'd1;
    localparam logic [1:0] RA_NODE   = 2'd2;
    localparam logic [1:0] RA_CMD    = 2'd3;

    localparam int CTL_EN    = 0;
    localparam int CTL_ADDR  = 1;
    localparam int CTL_CMIE  = 2;

    localparam int CMD_MUTE  = 0;
    localparam int CMD_CLRCM = 1;
    localparam int CMD_CLRFE = 2;

endpackage

// File: rtl/umr_sync.sv
module umr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[g] <= 1'b1;
                end else begin
                    chain_q[g] <= (g == 0) ? d_i : chain_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/umr_frame.sv
module umr_frame
    import uart_mute_pkg::*;
#(
    parameter int CLKS_PER_SAMPLE = 8,
    parameter int OSR             = 16,
    parameter int DATA_BITS       = 8,
    parameter int IDLE_BITS       = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable_i,
    input  logic                 rx_i,
    output logic                 busy_o,
    output logic                 hunting_o,
    output logic                 done_o,
    output logic                 ferr_o,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 idle_evt_o
);
    localparam int TICK_W   = $clog2(CLKS_PER_SAMPLE) + 1;
    localparam int SMP_W    = $clog2(OSR);
    localparam int BIT_W    = $clog2(DATA_BITS);
    localparam int MID      = OSR / 2;
    localparam int IDLE_LIM = IDLE_BITS * OSR;
    localparam int IDLE_W   = $clog2(IDLE_LIM + 1);

    frame_state_t state_q, state_nx;
    logic [TICK_W-1:0]    tick_cnt_q;
    logic                 tick;
    logic [SMP_W-1:0]     smp_q;
    logic [BIT_W-1:0]     bit_q;
    logic [DATA_BITS-1:0] shreg_q;
    logic [IDLE_W-1:0]    idle_q;
    logic                 smp_last, stop_point;

    // sample tick generator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt_q <= '0;
        end else if (!enable_i || tick_cnt_q == TICK_W'(CLKS_PER_SAMPLE - 1)) begin
            tick_cnt_q <= '0;
        end else begin
            tick_cnt_q <= tick_cnt_q + 1'b1;
        end
    end
    assign tick = enable_i && (tick_cnt_q == TICK_W'(CLKS_PER_SAMPLE - 1));

    assign smp_last   = (smp_q == SMP_W'(OSR - 1));
    assign stop_point = (state_q == FR_STOP) && tick && (smp_q == SMP_W'(MID));

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            FR_HUNT: begin
                if (tick && !rx_i) state_nx = FR_START_CHK;
            end
            FR_START_CHK: begin
                if (tick) begin
                    if (smp_q >= SMP_W'(MID - 1) && rx_i)  state_nx = FR_HUNT;
                    else if (smp_q == SMP_W'(MID + 1))     state_nx = FR_START_TAIL;
                end
            end
            FR_START_TAIL: begin
                if (tick && smp_last) state_nx = FR_DATA;
            end
            FR_DATA: begin
                if (tick && smp_last && bit_q == BIT_W'(DATA_BITS - 1)) state_nx = FR_STOP;
            end
            FR_STOP: begin
                if (tick && smp_q == SMP_W'(MID)) state_nx = FR_HUNT;
            end
            default: state_nx = FR_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FR_HUNT;
        else        state_q <= state_nx;
    end

    // counters, shifter and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q      <= '0;
            bit_q      <= '0;
            shreg_q    <= '0;
            done_o     <= 1'b0;
            ferr_o     <= 1'b0;
            data_o     <= '0;
            idle_q     <= '0;
            idle_evt_o <= 1'b0;
        end else begin
            done_o     <= stop_point;
            ferr_o     <= stop_point && !rx_i;
            idle_evt_o <= 1'b0;
            if (stop_point) data_o <= shreg_q;

            if (state_q == FR_HUNT) begin
                smp_q <= (tick && !rx_i) ? SMP_W'(1) : '0;
            end else if (tick) begin
                smp_q <= smp_last ? '0 : smp_q + 1'b1;
            end

            if (state_q == FR_START_TAIL) begin
                bit_q <= '0;
            end else if (state_q == FR_DATA && tick && smp_last) begin
                bit_q <= bit_q + 1'b1;
            end

            if (state_q == FR_DATA && tick && smp_q == SMP_W'(MID)) begin
                shreg_q <= {rx_i, shreg_q[DATA_BITS-1:1]};
            end

            if (state_q == FR_HUNT && enable_i && rx_i) begin
                if (tick && idle_q != IDLE_W'(IDLE_LIM)) begin
                    idle_q <= idle_q + 1'b1;
                    if (idle_q == IDLE_W'(IDLE_LIM - 1)) idle_evt_o <= 1'b1;
                end
            end else begin
                idle_q <= '0;
            end
        end
    end

    assign busy_o    = (state_q == FR_START_TAIL) || (state_q == FR_DATA) || (state_q == FR_STOP);
    assign hunting_o = (state_q == FR_HUNT);
endmodule

// File: rtl/umr_mute.sv
module umr_mute
    import uart_mute_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done_i,
    input  logic                 ferr_i,
    input  logic [DATA_BITS-1:0] data_i,
    input  logic                 addr_mode_i,
    input  logic [DATA_BITS-2:0] node_i,
    input  logic                 req_i,
    input  logic                 idle_evt_i,
    output logic                 muted_o,
    output logic                 deliver_o
);
    mute_state_t mst_q, mst_nx;
    logic good_char, is_addr, addr_hit;

    assign good_char = done_i && !ferr_i;
    assign is_addr   = addr_mode_i && data_i[DATA_BITS-1];
    assign addr_hit  = (data_i[DATA_BITS-2:0] == node_i);

    always_comb begin
        mst_nx = mst_q;
        unique case (mst_q)
            MT_ACTIVE: begin
                if (req_i)                                 mst_nx = MT_MUTED;
                else if (good_char && is_addr && !addr_hit) mst_nx = MT_MUTED;
            end
            MT_MUTED: begin
                if (req_i)                                  mst_nx = MT_MUTED;
                else if (good_char && is_addr && addr_hit)  mst_nx = MT_ACTIVE;
                else if (!addr_mode_i && idle_evt_i)        mst_nx = MT_ACTIVE;
            end
            default: mst_nx = MT_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mst_q <= MT_ACTIVE;
        else        mst_q <= mst_nx;
    end

    always_comb begin
        deliver_o = 1'b0;
        if (good_char) begin
            if (is_addr) deliver_o = addr_hit;
            else         deliver_o = (mst_q == MT_ACTIVE);
        end
    end

    assign muted_o = (mst_q == MT_MUTED);
endmodule

// File: rtl/uart_mute_rx.sv
module uart_mute_rx
    import uart_mute_pkg::*;
#(
    parameter int CLKS_PER_SAMPLE = 8,
    parameter int OSR             = 16,
    parameter int SYNC_STAGES     = 2,
    parameter int IDLE_BITS       = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_i,
    input  logic       wr_en_i,
    input  logic [1:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    input  logic [1:0] rd_addr_i,
    output logic [7:0] rd_data_o,
    output logic       rx_valid_o,
    output logic [7:0] rx_data_o,
    output logic       irq_o
);
    localparam int DATA_BITS = 8;

    logic [7:0] ctrl_q, match_q;
    logic [6:0] node_q;
    logic       rx_en_ack, cm_flag, fe_flag;
    logic       rx_s;
    logic       frame_busy, frame_hunting, frame_done, frame_ferr, frame_idle;
    logic [7:0] frame_data;
    logic       mute_flag, deliver;
    logic       cmd_wr, req_mute, clr_match, clr_ferr;
    logic       ctrl_addr_mode, ctrl_cm_ie;

    assign cmd_wr         = wr_en_i && (wr_addr_i == RA_CMD);
    assign req_mute       = cmd_wr && wr_data_i[CMD_MUTE];
    assign clr_match      = cmd_wr && wr_data_i[CMD_CLRCM];
    assign clr_ferr       = cmd_wr && wr_data_i[CMD_CLRFE];
    assign ctrl_addr_mode = ctrl_q[CTL_ADDR];
    assign ctrl_cm_ie     = ctrl_q[CTL_CMIE];

    umr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(rx_s)
    );

    umr_frame #(
        .CLKS_PER_SAMPLE(CLKS_PER_SAMPLE), .OSR(OSR),
        .DATA_BITS(DATA_BITS), .IDLE_BITS(IDLE_BITS)
    ) u_frame (
        .clk(clk), .rst_n(rst_n), .enable_i(rx_en_ack), .rx_i(rx_s),
        .busy_o(frame_busy), .hunting_o(frame_hunting), .done_o(frame_done),
        .ferr_o(frame_ferr), .data_o(frame_data), .idle_evt_o(frame_idle)
    );

    umr_mute #(.DATA_BITS(DATA_BITS)) u_mute (
        .clk(clk), .rst_n(rst_n), .done_i(frame_done), .ferr_i(frame_ferr),
        .data_i(frame_data), .addr_mode_i(ctrl_addr_mode), .node_i(node_q),
        .req_i(req_mute), .idle_evt_i(frame_idle),
        .muted_o(mute_flag), .deliver_o(deliver)
    );

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            match_q <= '0;
            node_q  <= '0;
        end else if (wr_en_i) begin
            unique case (wr_addr_i)
                RA_CTRL:  ctrl_q  <= wr_data_i;
                RA_MATCH: match_q <= wr_data_i;
                RA_NODE:  node_q  <= wr_data_i[6:0];
                RA_CMD:   ;
                default:  ;
            endcase
        end
    end

    // enable acknowledge, flags and data output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_en_ack  <= 1'b0;
            cm_flag    <= 1'b0;
            fe_flag    <= 1'b0;
            rx_valid_o <= 1'b0;
            rx_data_o  <= '0;
        end else begin
            if (frame_hunting) rx_en_ack <= ctrl_q[CTL_EN];

            rx_valid_o <= deliver;
            if (deliver) rx_data_o <= frame_data;

            if (deliver && frame_data == match_q) cm_flag <= 1'b1;
            else if (clr_match)                  cm_flag <= 1'b0;

            if (frame_done && frame_ferr) fe_flag <= 1'b1;
            else if (clr_ferr)           fe_flag <= 1'b0;
        end
    end

    assign irq_o = cm_flag && ctrl_cm_ie;

    always_comb begin
        unique case (rd_addr_i)
            RA_CTRL:  rd_data_o = ctrl_q;
            RA_MATCH: rd_data_o = match_q;
            RA_NODE:  rd_data_o = {1'b0, node_q};
            default:  rd_data_o = {3'b000, rx_en_ack, fe_flag, mute_flag, cm_flag, frame_busy};
        endcase
    end
endmodule

// File: rtl/uart_mute_rx_chk.sv
module uart_mute_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic hunting,
    input logic rx_valid,
    input logic mute,
    input logic addr_mode,
    input logic mute_req,
    input logic cm_flag,
    input logic cm_clr,
    input logic cm_ie,
    input logic irq,
    input logic ack
);
    AST_VALID_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(done)); // R1

    AST_BUSY_ENDS_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R3

    AST_MATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cm_flag && !cm_clr |=> cm_flag); // R5

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cm_ie); // R6

    AST_MUTED_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !$past(addr_mode) |-> !$past(mute)); // R7

    AST_IDLE_MODE_SW_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mute) && !$past(addr_mode) |-> $past(mute_req)); // R9

    AST_ACK_IN_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ack) |-> $past(hunting)); // R10
endmodule

bind uart_mute_rx uart_mute_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(frame_busy), .done(frame_done),
    .hunting(frame_hunting), .rx_valid(rx_valid_o), .mute(mute_flag),
    .addr_mode(ctrl_addr_mode), .mute_req(req_mute), .cm_flag(cm_flag),
    .cm_clr(clr_match), .cm_ie(ctrl_cm_ie), .irq(irq_o), .ack(rx_en_ack)
);

// File: tb/uart_mute_rx_tb.sv
module uart_mute_rx_tb;
    localparam int CPS      = 4;
    localparam int BIT_CLKS = 16 * CPS;
    // {expected compare hit, byte}; compare register = 0xA5
    localparam logic [8:0] VEC [0:4] = '{9'h055, 9'h000, 9'h0FF, 9'h1A5, 9'h03C};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = 2'd3;
    logic [7:0] rd_data, rx_data;
    logic       rx_valid, irq;

    int checks = 0, errors = 0;
    int vcount = 0;
    logic [7:0] last_byte = '0;
    logic busy_mid = 1'b0, busy_seen = 1'b0;

    always #2.5 clk = ~clk;

    uart_mute_rx #(.CLKS_PER_SAMPLE(CPS)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .rx_valid_o(rx_valid), .rx_data_o(rx_data), .irq_o(irq)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            vcount++;
            last_byte = rx_data;
        end
        if (rd_data[0]) busy_seen = 1'b1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input logic stop_val);
        @(negedge clk);
        rx = 1'b0;
        repeat (BIT_CLKS) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            repeat (BIT_CLKS / 2) @(negedge clk);
            if (i == 3) busy_mid = rd_data[0];
            repeat (BIT_CLKS / 2) @(negedge clk);
        end
        rx = stop_val;
        repeat (BIT_CLKS) @(negedge clk);
        rx = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 status", rd_data, 8'h00);
        chk("R11 valid", rx_valid, 0);
        chk("R11 irq", irq, 0);

        wr(2'd1, 8'hA5);
        wr(2'd0, 8'h01);
        repeat (3) @(negedge clk);
        chk("R10 ack set", rd_data[4], 1);

        // table-driven reception and compare
        foreach (VEC[k]) begin
            wr(2'd3, 8'h02);
            v0 = vcount;
            send(VEC[k][7:0], 1'b1);
            chk("R1 one strobe", vcount, v0 + 1);
            chk("R1 data", last_byte, VEC[k][7:0]);
            chk("R5 compare", rd_data[1], VEC[k][8]);
            chk("R3 busy mid", busy_mid, 1);
            chk("R3 busy end", rd_data[0], 0);
        end

        // short glitch
        repeat (BIT_CLKS) @(negedge clk);
        busy_seen = 1'b0; v0 = vcount;
        rx = 1'b0;
        repeat (3 * CPS) @(negedge clk);
        rx = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
        chk("R2 no busy", busy_seen, 0);
        chk("R2 no char", vcount, v0);

        // compare flag, stickiness, interrupt
        wr(2'd3, 8'h02);
        send(8'hA5, 1'b1);
        chk("R6 irq masked", irq, 0);
        send(8'h11, 1'b1);
        chk("R5 sticky", rd_data[1], 1);
        wr(2'd0, 8'h05);
        @(negedge clk);
        chk("R6 irq on", irq, 1);
        wr(2'd3, 8'h02);
        chk("R5 cleared", rd_data[1], 0);
        chk("R6 irq off", irq, 0);

        // framing error
        v0 = vcount;
        send(8'h5A, 1'b0);
        repeat (2 * BIT_CLKS) @(negedge clk);
        chk("R4 ferr set", rd_data[3], 1);
        chk("R4 no strobe", vcount, v0);
        chk("R3 busy mid bad", busy_mid, 1);
        chk("R3 busy end bad", rd_data[0], 0);
        wr(2'd3, 8'h04);
        chk("R4 ferr clear", rd_data[3], 0);

        // idle mode mute
        wr(2'd3, 8'h01);
        chk("R9 req mutes", rd_data[2], 1);
        v0 = vcount;
        send(8'hA5, 1'b1);
        chk("R7 no strobe", vcount, v0);
        chk("R7 no compare", rd_data[1], 0);
        chk("R9 still muted", rd_data[2], 1);
        repeat (12 * BIT_CLKS) @(negedge clk);
        chk("R9 idle wakes", rd_data[2], 0);
        v0 = vcount;
        send(8'h85, 1'b1);
        chk("R9 no hw mute", rd_data[2], 0);
        chk("R9 addr byte delivered", vcount, v0 + 1);

        // address mode
        wr(2'd2, 8'h12);
        wr(2'd0, 8'h03);
        wr(2'd1, 8'h33);
        wr(2'd3, 8'h02);
        v0 = vcount;
        send(8'h85, 1'b1);
        chk("R8 mismatch mutes", rd_data[2], 1);
        chk("R8 mismatch dropped", vcount, v0);
        send(8'h33, 1'b1);
        chk("R7 muted data dropped", vcount, v0);
        chk("R7 muted no compare", rd_data[1], 0);
        repeat (12 * BIT_CLKS) @(negedge clk);
        chk("R8 idle no wake", rd_data[2], 1);
        send(8'h92, 1'b1);
        chk("R8 match wakes", rd_data[2], 0);
        chk("R8 match delivered", vcount, v0 + 1);
        chk("R8 match data", last_byte, 8'h92);
        send(8'h33, 1'b1);
        chk("R8 data after wake", last_byte, 8'h33);
        chk("R5 compare addr mode", rd_data[1], 1);

        // disable mid-frame
        v0 = vcount;
        fork
            send(8'h3C, 1'b1);
            begin
                repeat (4 * BIT_CLKS) @(negedge clk);
                wr(2'd0, 8'h02);
                @(negedge clk);
                chk("R10 ack held", rd_data[4], 1);
            end
        join
        chk("R10 frame completes", vcount, v0 + 1);
        chk("R10 ack cleared", rd_data[4], 0);
        send(8'h11, 1'b1);
        chk("R10 disabled ignores", vcount, v0 + 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule